// File: doc/BRIEF.md
# Dual-Port Write-Through Data Cache

This block is a 16 KB primary data cache. It is direct mapped, with 512 lines of 32 bytes. It has two 64-bit request ports. In any cycle it can finish two loads, or one load and one store. Two stores never finish together. The line is selected by virtual address bits. The hit test compares the stored tag with a physical tag that the requester presents alongside the virtual bits, so translation can run in parallel with the array lookup.

Every store that finishes is forwarded to the next memory level on a registered write-through channel. A store that misses first allocates the line and then merges its enabled bytes. A miss holds the requester off for a fixed time. The refill pulls the line as four 64-bit beats from a lower-level read port that answers one cycle after each read strobe. The stalled request then finishes exactly eight cycles after the miss was first seen. The arrays hold no parity or check bits.

Top module: `dcache_dp`

## Requirements
- R1: After reset every line is invalid. `req_ready_o`, `fill_rd_o` and `wt_valid_o` are low with no requests, and the first access to any address misses.
- R2: A load to a valid line finishes in the cycle it is presented, with `req_ready_o` high, when the stored tag equals `req_ptag_i`. `rsp_rdata_o` then carries the doubleword at `req_va_i`, which is line index in bits [10:2] and doubleword in line in bits [1:0].
- R3: Two hitting loads on both ports, or a load and a store, finish in the same cycle. When both ports present stores, port 0 finishes and port 1 is held for that cycle.
- R4: Each finished store gives one cycle of `wt_valid_o` in the next cycle. It carries `wt_addr_o = {req_ptag_i, req_va_i}` (doubleword address), the store data and the byte mask.
- R5: Bit i of `req_be_i` enables byte i, which is data bits 8i+7:8i. Only enabled bytes change in the cache.
- R6: A miss seen in cycle t raises `fill_rd_o` in cycles t+1 to t+4, with `fill_addr_o = {tag, index, beat}` for beats 0,1,2,3 in that order. `fill_data_i` is taken one cycle after each strobe.
- R7: A request that misses in cycle t and is held finishes in cycle t+8. Neither port finishes anything in cycles t+1 to t+7.
- R8: A store miss allocates the line, merges its bytes over the refilled data, and finishes in cycle t+8. Later loads to that line hit with the merged data.
- R9: A request whose physical tag differs from the stored tag at the same index misses and replaces the line.
- R10: When both ports miss in the same cycle, port 0 is refilled first. Port 1 starts its own refill in the cycle port 0 finishes.
- R11: A load and a store to the same doubleword in one cycle return the data held before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 2 | Request present, one bit per port |
| req_we_i | input | 2 | Request is a store, per port |
| req_va_i | input | 2x11 | Virtual doubleword address bits 13:3, per port |
| req_ptag_i | input | 2x18 | Physical tag, address bits 31:14, per port |
| req_wdata_i | input | 2x64 | Store data, per port |
| req_be_i | input | 2x8 | Store byte enables, per port |
| req_ready_o | output | 2 | Request finishes this cycle, per port |
| rsp_rdata_o | output | 2x64 | Load data, valid with ready |
| fill_rd_o | output | 1 | Refill read strobe |
| fill_addr_o | output | 29 | Refill doubleword physical address |
| fill_data_i | input | 64 | Refill data, one cycle after the strobe |
| wt_valid_o | output | 1 | Write-through valid |
| wt_addr_o | output | 29 | Write-through doubleword physical address |
| wt_data_o | output | 64 | Write-through data |
| wt_be_o | output | 8 | Write-through byte mask |

## Verification
Different internal faults show up at the ports at different times. A wrong valid bit or a stale tag changes whether a request finishes at once or eight cycles later, so it is visible on the first access to that line. A wrong refill beat order or a wrong merge corrupts data silently until a later load reads that doubleword. For this reason every store is followed by loads of the same word, and refill addresses are checked beat by beat. Arbitration faults show in the same cycle as a second ready, or as an out-of-order write-through on the following cycle.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned NPORTS   = 2;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned LANE_SEL = $clog2(LANES);
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int unsigned LINES = 512,
  parameter int unsigned TAG_W = 18,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [dc_pkg::NPORTS-1:0][IDX_W-1:0]    rd_idx_i,
  input  logic [dc_pkg::NPORTS-1:0][TAG_W-1:0]    rd_tag_i,
  output logic [dc_pkg::NPORTS-1:0]               hit_o,
  input  logic                                    we_i,
  input  logic [IDX_W-1:0]                        wr_idx_i,
  input  logic [TAG_W-1:0]                        wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_q <= '0;
    else if (we_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  for (genvar p = 0; p < dc_pkg::NPORTS; p++) begin : g_cmp
    assign hit_o[p] = valid_q[rd_idx_i[p]] && (tag_q[rd_idx_i[p]] == rd_tag_i[p]);
  end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                                             clk_i,
  input  logic [dc_pkg::NPORTS-1:0][AW-1:0]                rd_addr_i,
  output logic [dc_pkg::NPORTS-1:0][dc_pkg::WORD_W-1:0]    rd_data_o,
  input  logic                                             wr_en_i,
  input  logic [AW-1:0]                                    wr_addr_i,
  input  logic [dc_pkg::WORD_W-1:0]                        wr_data_i,
  input  logic [dc_pkg::LANES-1:0]                         wr_be_i
);
  // one byte-wide array per lane keeps byte writes single-driven
  for (genvar b = 0; b < dc_pkg::LANES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[b]) lane_q[wr_addr_i] <= wr_data_i[8*b +: 8];
    end

    for (genvar p = 0; p < dc_pkg::NPORTS; p++) begin : g_rd
      assign rd_data_o[p][8*b +: 8] = lane_q[rd_addr_i[p]];
    end
  end
endmodule

// File: rtl/dc_refill_ctrl.sv
module dc_refill_ctrl #(
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned TAG_W   = 18,
  parameter int unsigned WSEL_W  = 2,
  parameter int unsigned PENALTY = 8,
  localparam int unsigned BEATS  = 1 << WSEL_W,
  localparam int unsigned CNT_W  = $clog2(PENALTY)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [IDX_W-1:0]                start_idx_i,
  input  logic [TAG_W-1:0]                start_tag_i,
  output logic                            busy_o,
  output logic                            fill_rd_o,
  output logic [TAG_W+IDX_W+WSEL_W-1:0]   fill_addr_o,
  output logic                            fill_wr_o,
  output logic [IDX_W+WSEL_W-1:0]         fill_waddr_o,
  output logic                            tag_we_o,
  output logic [IDX_W-1:0]                tag_idx_o,
  output logic [TAG_W-1:0]                tag_val_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_m1;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              rd_q;
  logic [WSEL_W-1:0] rbeat_q, beat;

  assign cnt_m1 = cnt_q - CNT_W'(1);
  assign beat   = cnt_m1[WSEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      tag_q <= '0;
    end else if (cnt_q == '0) begin
      if (start_i) begin
        cnt_q <= CNT_W'(1);
        idx_q <= start_idx_i;
        tag_q <= start_tag_i;
      end
    end else if (cnt_q == CNT_W'(PENALTY - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // lower level answers one cycle after each strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      rbeat_q <= '0;
    end else begin
      rd_q    <= fill_rd_o;
      rbeat_q <= beat;
    end
  end

  assign busy_o       = (cnt_q != '0);
  assign fill_rd_o    = (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(BEATS));
  assign fill_addr_o  = {tag_q, idx_q, beat};
  assign fill_wr_o    = rd_q;
  assign fill_waddr_o = {idx_q, rbeat_q};
  assign tag_we_o     = (cnt_q == CNT_W'(BEATS + 1));
  assign tag_idx_o    = idx_q;
  assign tag_val_o    = tag_q;
endmodule

// File: rtl/dcache_dp.sv
module dcache_dp #(
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned NUM_LINES  = 512,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned PENALTY    = 8,
  localparam int unsigned BSEL_W  = dc_pkg::LANE_SEL,
  localparam int unsigned WSEL_W  = $clog2(LINE_BYTES / dc_pkg::LANES),
  localparam int unsigned IDX_W   = $clog2(NUM_LINES),
  localparam int unsigned DVA_W   = IDX_W + WSEL_W,
  localparam int unsigned TAG_W   = PA_W - DVA_W - BSEL_W,
  localparam int unsigned WADDR_W = PA_W - BSEL_W,
  localparam int unsigned W       = dc_pkg::WORD_W,
  localparam int unsigned NB      = dc_pkg::LANES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            req_valid_i,
  input  logic [1:0]            req_we_i,
  input  logic [1:0][DVA_W-1:0] req_va_i,
  input  logic [1:0][TAG_W-1:0] req_ptag_i,
  input  logic [1:0][W-1:0]     req_wdata_i,
  input  logic [1:0][NB-1:0]    req_be_i,
  output logic [1:0]            req_ready_o,
  output logic [1:0][W-1:0]     rsp_rdata_o,
  output logic                  fill_rd_o,
  output logic [WADDR_W-1:0]    fill_addr_o,
  input  logic [W-1:0]          fill_data_i,
  output logic                  wt_valid_o,
  output logic [WADDR_W-1:0]    wt_addr_o,
  output logic [W-1:0]          wt_data_o,
  output logic [NB-1:0]         wt_be_o
);
  logic [1:0][IDX_W-1:0] idx;
  logic [1:0]            hit, grant, done, miss, st_done;
  logic                  busy, st_clash, st_en, st_sel, start, start_sel;
  logic                  fill_wr, tag_we;
  logic [DVA_W-1:0]      fill_waddr;
  logic [IDX_W-1:0]      tag_widx;
  logic [TAG_W-1:0]      tag_wval;
  logic                  d_we;
  logic [DVA_W-1:0]      d_addr;
  logic [W-1:0]          d_data;
  logic [NB-1:0]         d_be;

  for (genvar p = 0; p < 2; p++) begin : g_idx
    assign idx[p] = req_va_i[p][DVA_W-1:WSEL_W];
  end

  // port 1 store yields to a port 0 store
  assign st_clash  = req_valid_i[0] & req_we_i[0] & req_valid_i[1] & req_we_i[1];
  assign grant[0]  = req_valid_i[0] & ~busy;
  assign grant[1]  = req_valid_i[1] & ~busy & ~st_clash;
  assign done      = grant & hit;
  assign miss      = grant & ~hit;
  assign start     = |miss;
  assign start_sel = ~miss[0];
  assign st_done   = done & req_we_i;
  assign st_en     = |st_done;
  assign st_sel    = ~st_done[0];

  assign req_ready_o = done;

  dc_tag_store #(.LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx),
    .rd_tag_i (req_ptag_i),
    .hit_o    (hit),
    .we_i     (tag_we),
    .wr_idx_i (tag_widx),
    .wr_tag_i (tag_wval)
  );

  dc_refill_ctrl #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W), .PENALTY(PENALTY)
  ) u_refill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_idx_i  (idx[start_sel]),
    .start_tag_i  (req_ptag_i[start_sel]),
    .busy_o       (busy),
    .fill_rd_o    (fill_rd_o),
    .fill_addr_o  (fill_addr_o),
    .fill_wr_o    (fill_wr),
    .fill_waddr_o (fill_waddr),
    .tag_we_o     (tag_we),
    .tag_idx_o    (tag_widx),
    .tag_val_o    (tag_wval)
  );

  // refill and store writes never overlap: stores finish only when idle
  assign d_we   = fill_wr | st_en;
  assign d_addr = fill_wr ? fill_waddr  : req_va_i[st_sel];
  assign d_data = fill_wr ? fill_data_i : req_wdata_i[st_sel];
  assign d_be   = fill_wr ? '1          : req_be_i[st_sel];

  dc_data_store #(.DEPTH(NUM_LINES << WSEL_W)) u_data (
    .clk_i     (clk_i),
    .rd_addr_i (req_va_i),
    .rd_data_o (rsp_rdata_o),
    .wr_en_i   (d_we),
    .wr_addr_i (d_addr),
    .wr_data_i (d_data),
    .wr_be_i   (d_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_valid_o <= 1'b0;
      wt_addr_o  <= '0;
      wt_data_o  <= '0;
      wt_be_o    <= '0;
    end else begin
      wt_valid_o <= st_en;
      if (st_en) begin
        wt_addr_o <= {req_ptag_i[st_sel], req_va_i[st_sel]};
        wt_data_o <= req_wdata_i[st_sel];
        wt_be_o   <= req_be_i[st_sel];
      end
    end
  end
endmodule

// File: rtl/dcache_dp_chk.sv
module dcache_dp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_valid_i,
  input logic [1:0] req_we_i,
  input logic [1:0] req_ready_o,
  input logic       fill_rd_o,
  input logic       wt_valid_o
);
  logic [1:0] st_fin;
  assign st_fin = req_valid_i & req_we_i & req_ready_o;

  a_r3_one_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_fin[0] && st_fin[1]));

  a_r3_port0_store_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i == 2'b11 && req_we_i == 2'b11) |-> !req_ready_o[1]);

  a_r2_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == 2'b00);

  a_r4_wt_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|st_fin) |=> wt_valid_o);

  a_r4_wt_only_from_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_valid_o |-> $past(|st_fin));

  a_r7_no_finish_in_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_rd_o |-> (req_ready_o == 2'b00));

  a_r6_fill_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_rd_o) |=> fill_rd_o);
endmodule

bind dcache_dp dcache_dp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_ready_o (req_ready_o),
  .fill_rd_o   (fill_rd_o),
  .wt_valid_o  (wt_valid_o)
);

// File: tb/tb_dcache_dp.sv
`timescale 1ns/1ps
module tb_dcache_dp;
  typedef struct packed {
    logic        v;
    logic        we;
    logic [10:0] va;
    logic [17:0] tag;
    logic [63:0] wd;
    logic [7:0]  be;
  } req_t;

  typedef struct packed {
    req_t       r;
    logic [4:0] lat;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{'{1'b1, 1'b0, 11'h008, 18'h00011, 64'h0, 8'h00}, 5'd8},                   // R1 R6 R7 cold miss
    '{'{1'b1, 1'b0, 11'h009, 18'h00011, 64'h0, 8'h00}, 5'd0},                   // R2 hit
    '{'{1'b1, 1'b1, 11'h00A, 18'h00011, 64'h1122334455667788, 8'h0F}, 5'd0},    // R5 masked store
    '{'{1'b1, 1'b0, 11'h00A, 18'h00011, 64'h0, 8'h00}, 5'd0},                   // R5 readback
    '{'{1'b1, 1'b1, 11'h240, 18'h00022, 64'hCAFEF00DDEADBEEF, 8'hC3}, 5'd8},    // R8 store miss
    '{'{1'b1, 1'b0, 11'h240, 18'h00022, 64'h0, 8'h00}, 5'd0},                   // R8 readback
    '{'{1'b1, 1'b0, 11'h008, 18'h00033, 64'h0, 8'h00}, 5'd8},                   // R9 tag mismatch
    '{'{1'b1, 1'b0, 11'h009, 18'h00011, 64'h0, 8'h00}, 5'd8}                    // R9 replaced
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req_valid = '0, req_we = '0;
  logic [1:0][10:0] req_va = '0;
  logic [1:0][17:0] req_ptag = '0;
  logic [1:0][63:0] req_wdata = '0;
  logic [1:0][7:0]  req_be = '0;
  logic [1:0]       req_ready;
  logic [1:0][63:0] rsp_rdata;
  logic             fill_rd;
  logic [28:0]      fill_addr;
  logic [63:0]      fill_data = '0;
  logic             wt_valid;
  logic [28:0]      wt_addr;
  logic [63:0]      wt_data;
  logic [7:0]       wt_be;

  int checks = 0, errors = 0;
  logic [63:0] shadow [logic [28:0]];

  int          rc [2];
  logic [63:0] rd [2], exp_rd [2];
  logic        fl_rd [20], wt_v [20];
  logic [28:0] fl_addr [20], wt_a [20];
  logic [63:0] wt_d [20];
  logic [7:0]  wt_b [20];
  logic [1:0]  rdy [20];

  always #5 clk = ~clk;

  dcache_dp dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_va_i(req_va),
    .req_ptag_i(req_ptag), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_ready_o(req_ready), .rsp_rdata_o(rsp_rdata),
    .fill_rd_o(fill_rd), .fill_addr_o(fill_addr), .fill_data_i(fill_data),
    .wt_valid_o(wt_valid), .wt_addr_o(wt_addr), .wt_data_o(wt_data), .wt_be_o(wt_be)
  );

  function automatic logic [63:0] sget(input logic [28:0] a);
    if (shadow.exists(a)) return shadow[a];
    return {3'b101, a, 3'b010, ~a};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] w,
                                        input logic [7:0] be);
    for (int b = 0; b < 8; b++) if (be[b]) o[8*b +: 8] = w[8*b +: 8];
    return o;
  endfunction

  // lower level: one-cycle read latency
  always @(posedge clk) fill_data <= fill_rd ? sget(fill_addr) : 64'h0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input req_t a, input req_t b);
    req_t r [2];
    r[0] = a; r[1] = b;
    for (int p = 0; p < 2; p++) begin
      rc[p] = -1;
      rd[p] = '0;
      exp_rd[p] = sget({r[p].tag, r[p].va});
    end
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      req_valid[p] = r[p].v; req_we[p] = r[p].we; req_va[p] = r[p].va;
      req_ptag[p] = r[p].tag; req_wdata[p] = r[p].wd; req_be[p] = r[p].be;
    end
    for (int k = 0; k < 20; k++) begin
      #4;
      fl_rd[k] = fill_rd; fl_addr[k] = fill_addr; rdy[k] = req_ready;
      wt_v[k] = wt_valid; wt_a[k] = wt_addr; wt_d[k] = wt_data; wt_b[k] = wt_be;
      for (int p = 0; p < 2; p++) begin
        if (req_valid[p] && rc[p] < 0 && req_ready[p]) begin
          rc[p] = k;
          rd[p] = rsp_rdata[p];
          if (r[p].we) shadow[{r[p].tag, r[p].va}] = merge(sget({r[p].tag, r[p].va}),
                                                            r[p].wd, r[p].be);
        end
      end
      @(negedge clk);
      for (int p = 0; p < 2; p++) if (rc[p] >= 0) req_valid[p] = 1'b0;
    end
  endtask

  task automatic chk_wt(input int k, input req_t r, input string req);
    chk(wt_v[k] == 1'b1, req, 64'(wt_v[k]), 64'h1);
    chk(wt_a[k] == {r.tag, r.va}, req, 64'(wt_a[k]), 64'({r.tag, r.va}));
    chk(wt_d[k] == r.wd, req, wt_d[k], r.wd);
    chk(wt_b[k] == r.be, req, 64'(wt_b[k]), 64'(r.be));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req_t a, b, none;
    none = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #4;
    // R1 reset state at the ports
    chk(req_ready == 2'b00, "R1", 64'(req_ready), 64'h0);
    chk(fill_rd == 1'b0, "R1", 64'(fill_rd), 64'h0);
    chk(wt_valid == 1'b0, "R1", 64'(wt_valid), 64'h0);

    foreach (VEC[i]) begin
      run(VEC[i].r, none);
      chk(rc[0] == int'(VEC[i].lat), "R7 R2 latency", 64'(rc[0]), 64'(VEC[i].lat));
      if (!VEC[i].r.we) chk(rd[0] == exp_rd[0], "R2 R5 R8 data", rd[0], exp_rd[0]);
      else chk_wt(rc[0] + 1, VEC[i].r, "R4 write-through");
      if (VEC[i].lat == 5'd8) begin
        for (int k = 1; k <= 4; k++) begin
          chk(fl_rd[k] && fl_addr[k] == {VEC[i].r.tag, VEC[i].r.va[10:2], 2'(k - 1)},
              "R6 fill beat", 64'(fl_addr[k]),
              64'({VEC[i].r.tag, VEC[i].r.va[10:2], 2'(k - 1)}));
        end
        chk(fl_rd[5] == 1'b0, "R6 fill length", 64'(fl_rd[5]), 64'h0);
      end
    end

    // R3 two loads in one cycle
    a = '{1'b1, 1'b0, 11'h009, 18'h00011, 64'h0, 8'h00};
    b = '{1'b1, 1'b0, 11'h240, 18'h00022, 64'h0, 8'h00};
    run(a, b);
    chk(rc[0] == 0 && rc[1] == 0, "R3 dual load", 64'({rc[0][7:0], rc[1][7:0]}), 64'h0);
    chk(rd[1] == exp_rd[1], "R3 port1 data", rd[1], exp_rd[1]);

    // R3 two stores: port 0 first, port 1 one cycle later
    a = '{1'b1, 1'b1, 11'h00B, 18'h00011, 64'hA0A1A2A3A4A5A6A7, 8'hFF};
    b = '{1'b1, 1'b1, 11'h241, 18'h00022, 64'hB0B1B2B3B4B5B6B7, 8'hF0};
    run(a, b);
    chk(rc[0] == 0, "R3 store port0", 64'(rc[0]), 64'h0);
    chk(rc[1] == 1 && rdy[0][1] == 1'b0, "R3 store port1 held", 64'(rc[1]), 64'h1);
    chk_wt(1, a, "R4 store order p0");
    chk_wt(2, b, "R4 store order p1");
    run(none, '{1'b1, 1'b0, 11'h241, 18'h00022, 64'h0, 8'h00});
    chk(rd[1] == exp_rd[1] && rc[1] == 0, "R5 port1 merge", rd[1], exp_rd[1]);

    // R11 load and store to one word in one cycle
    a = '{1'b1, 1'b1, 11'h009, 18'h00011, 64'h0123456789ABCDEF, 8'hFF};
    b = '{1'b1, 1'b0, 11'h009, 18'h00011, 64'h0, 8'h00};
    run(a, b);
    chk(rc[0] == 0 && rc[1] == 0, "R3 load+store", 64'({rc[0][7:0], rc[1][7:0]}), 64'h0);
    chk(rd[1] == exp_rd[1], "R11 old data", rd[1], exp_rd[1]);
    run(b, none);
    chk(rd[0] == 64'h0123456789ABCDEF, "R11 new data", rd[0], 64'h0123456789ABCDEF);

    // R10 both ports miss
    a = '{1'b1, 1'b0, 11'h100, 18'h00044, 64'h0, 8'h00};
    b = '{1'b1, 1'b0, 11'h180, 18'h00055, 64'h0, 8'h00};
    run(a, b);
    chk(rc[0] == 8, "R10 port0 first", 64'(rc[0]), 64'h8);
    chk(rc[1] == 16, "R10 port1 second", 64'(rc[1]), 64'h10);
    for (int k = 1; k <= 7; k++) chk(rdy[k] == 2'b00, "R7 stall", 64'(rdy[k]), 64'h0);
    chk(rd[0] == exp_rd[0] && rd[1] == exp_rd[1], "R10 data", rd[1], exp_rd[1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule